// File: doc/BRIEF.md
# Timer input capture unit with noise filter

This block snapshots a free-running timer value into a capture register when a qualified edge arrives on a trigger input. The trigger is either an external pin or an internal alternate line, such as a comparator output. A source-select bit picks one of the two. The selected line is synchronized through two flops. An optional noise filter can then be switched in. The filter accepts a new level only after four consecutive equal samples. An edge-select bit decides whether rising or falling transitions count.

Each recognized edge copies the timer count into the capture register and sets a capture flag. Software clears the flag by writing one, which reaches the block as a single-cycle clear strobe. The interrupt output is the flag gated by an interrupt-enable bit. A later capture overwrites the register even when the flag is still set. The timer counter and the comparator are outside the block.

Top module: `icap_unit`

## Requirements
- R1: A recognized edge loads `count_i` into `cap_o` and sets `flag_o` on the same clock edge.
- R2: With `edge_rise_i`=1 only 0-to-1 transitions of the trigger are recognized. With `edge_rise_i`=0 only 1-to-0 transitions are recognized.
- R3: `src_alt_i`=1 selects `alt_i` as the trigger and `src_alt_i`=0 selects `pin_i`. Activity on the unselected line has no effect on `flag_o` or `cap_o`.
- R4: With the filter off, a trigger change set up before rising clock edge k is captured at edge k+2. The stored value is `count_i` as sampled at that edge.
- R5: With `filt_en_i`=1, a level must be sampled four consecutive times before it is accepted. Trigger pulses shorter than four cycles are dropped. A change held at least four cycles is captured at edge k+6, four edges later than in R4.
- R6: `flag_clr_i`=1 at a clock edge clears `flag_o`. If a capture happens at the same edge, the set wins and `flag_o` stays 1.
- R7: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R8: A capture while `flag_o` is already 1 still overwrites `cap_o` with the new count.
- R9: After reset `cap_o`=0, `flag_o`=0 and `irq_o`=0, and the filtered and previous levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | 16 | Live timer count |
| pin_i | input | 1 | External capture pin |
| alt_i | input | 1 | Alternate trigger line (comparator output) |
| src_alt_i | input | 1 | 1: use alt_i, 0: use pin_i |
| edge_rise_i | input | 1 | 1: rising edge, 0: falling edge |
| filt_en_i | input | 1 | Enable four-sample noise filter |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one clear strobe for the flag |
| cap_o | output | 16 | Captured count |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Capture interrupt |

## Verification
Directed cases cover each edge polarity with both transition directions, which separates matching edges from ignored ones. They also cover pulses of three and four cycles with the filter on, which locates the acceptance threshold exactly. Toggling the unselected source shows it is isolated. A clear strobe issued on the capture edge checks that the set wins. Random trials draw the base level, polarity, filter, source and a pulse length of 1 to 8 cycles, and then check the flag and captured count at the exact latency edge. These trials distinguish the filtered and unfiltered latencies and an off-by-one in the count sample.

// File: rtl/icap_pkg.sv
package icap_pkg;
  parameter int unsigned CNT_W       = 16;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned FILT_LEN    = 4;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic filt_o
);
  localparam int unsigned HW = LEN - 1;

  logic [HW-1:0] hist_q;
  logic [LEN-1:0] win;
  logic          filt_q;

  assign win = {hist_q, s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= win[HW-1:0];
      if (&win)       filt_q <= 1'b1;
      else if (~|win) filt_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;

  // R5: accepted level was seen on consecutive samples
  a_r5_filt_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> (filt_q == $past(s_i)) && ($past(s_i) == $past(s_i, 2)));
endmodule

// File: rtl/icap_edge_cap.sv
module icap_edge_cap #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_i,
  input  logic         rise_sel_i,
  input  logic         clr_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] cap_o,
  output logic         flag_o
);
  logic         prev_q;
  logic         flag_q;
  logic [W-1:0] cap_q;
  logic         evt;

  assign evt = (level_i ^ prev_q) & (level_i == rise_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      prev_q <= level_i;
      if (evt) cap_q <= count_i;
      // set has priority over clear
      if (evt)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  // R1/R8: register only moves together with a set flag
  a_r1_cap_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_q) |-> flag_q);

  // R2: a new flag follows a level that matches the selected polarity
  a_r2_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(level_i) == $past(rise_sel_i));

  // R6: clear with no level change drops the flag
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && $stable(level_i) |=> !flag_q);

  // R6: clear never defeats a capture
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !$stable(cap_q) |-> flag_q);
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_i,
  input  logic             alt_i,
  input  logic             src_alt_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic trig_raw, trig_s, trig_f, level;

  assign trig_raw = src_alt_i ? alt_i : pin_i;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(trig_raw), .q_o(trig_s)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .s_i(trig_s), .filt_o(trig_f)
  );

  assign level = filt_en_i ? trig_f : trig_s;

  icap_edge_cap #(.W(CNT_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .rise_sel_i(edge_rise_i),
    .clr_i     (flag_clr_i),
    .count_i   (count_i),
    .cap_o     (cap_o),
    .flag_o    (flag_o)
  );

  assign irq_o = flag_o & irq_en_i;

  // R7: interrupt never raised while masked
  a_r7_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/icap_unit_tb_top.sv
module icap_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] count_i = 16'h0100;
  logic        pin_i = 0, alt_i = 0, src_alt_i = 0, edge_rise_i = 1;
  logic        filt_en_i = 0, irq_en_i = 0, flag_clr_i = 0;
  logic [15:0] cap_o;
  logic        flag_o, irq_o;

  int n_chk = 0, n_bad = 0;

  icap_unit dut_i (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) count_i <= count_i + 16'd1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
  endtask

  function automatic logic cap_expected(logic newlvl, logic rise, logic filt, int len);
    return (newlvl == rise) && (!filt || len >= 4);
  endfunction

  // drive selected source to v, check flag/count at capture latency
  task automatic edge_case(string tag, logic v, logic exp_cap);
    logic [15:0] c0;
    int lat;
    lat = filt_en_i ? 7 : 3;
    c0 = count_i;
    if (src_alt_i) alt_i = v; else pin_i = v;
    step(lat - 1);
    chk({tag, " early"}, flag_o, 1'b0);
    step(1);
    chk({tag, " flag"}, flag_o, exp_cap);
    if (exp_cap) chk({tag, " cap"}, cap_o, c0 + 16'(lat - 1));
  endtask

  initial begin : watchdog
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] c0, c1;
    void'($urandom(32'd4242));
    #23; rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk("R9 cap", cap_o, 16'h0);
    chk("R9 flag", flag_o, 1'b0);
    chk("R9 irq", irq_o, 1'b0);

    // R1 R4 R2 rising edge, unfiltered
    edge_case("R1 R4 rise", 1'b1, 1'b1);
    // R7 irq gating
    irq_en_i = 1; #1; chk("R7 irq on", irq_o, 1'b1);
    irq_en_i = 0; #1; chk("R7 irq off", irq_o, 1'b0);
    clr_flag();
    chk("R6 cleared", flag_o, 1'b0);
    // R2 falling ignored in rising mode
    edge_case("R2 fall ignored", 1'b0, 1'b0);
    step(4); chk("R2 fall ignored late", flag_o, 1'b0);
    // R2 falling mode
    edge_rise_i = 0; step(2);
    edge_case("R2 rise ignored", 1'b1, 1'b0);
    edge_case("R2 fall", 1'b0, 1'b1);
    clr_flag();

    // R8 overwrite while flag set
    edge_rise_i = 1; step(2);
    edge_case("R8 first", 1'b1, 1'b1);
    pin_i = 0; step(3);
    c1 = count_i; pin_i = 1; step(3);
    chk("R8 overwrite", cap_o, c1 + 16'd2);
    chk("R8 flag", flag_o, 1'b1);
    clr_flag();

    // R6 clear coincides with capture edge: set wins
    pin_i = 0; step(4);
    c0 = count_i; pin_i = 1; step(2);
    flag_clr_i = 1; step(1); flag_clr_i = 0;
    chk("R6 set wins", flag_o, 1'b1);
    chk("R6 set wins cap", cap_o, c0 + 16'd2);
    clr_flag();

    // R3 alternate source, pin ignored
    pin_i = 0; alt_i = 0; step(4); clr_flag();
    src_alt_i = 1; step(4);
    pin_i = 1; step(5); pin_i = 0; step(5);
    chk("R3 pin ignored", flag_o, 1'b0);
    edge_case("R3 alt", 1'b1, 1'b1);
    clr_flag();
    alt_i = 0; step(5); clr_flag();
    src_alt_i = 0; step(4);
    alt_i = 1; step(5); alt_i = 0; step(5);
    chk("R3 alt ignored", flag_o, 1'b0);

    // R5 filter threshold
    filt_en_i = 1; step(6); clr_flag();
    pin_i = 1; step(3); pin_i = 0; step(10);
    chk("R5 3-cycle drop", flag_o, 1'b0);
    c0 = count_i; pin_i = 1; step(4); pin_i = 0; step(3);
    chk("R5 4-cycle pass", flag_o, 1'b1);
    chk("R5 4-cycle cap", cap_o, c0 + 16'd6);
    step(10); clr_flag();
    edge_case("R5 latency", 1'b1, 1'b1);
    pin_i = 0; step(10); clr_flag();

    // random trials
    for (int it = 0; it < 300; it++) begin
      logic b, rise, filt, src, expc;
      int len, lat;
      b = 1'($urandom); rise = 1'($urandom);
      filt = 1'($urandom); src = 1'($urandom);
      len = 1 + int'($urandom % 8);
      pin_i = b; alt_i = b; edge_rise_i = rise; filt_en_i = filt; src_alt_i = src;
      step(10); clr_flag(); step(1);
      expc = cap_expected(~b, rise, filt, len);
      lat = filt ? 7 : 3;
      c0 = count_i;
      if (src) alt_i = ~b; else pin_i = ~b;
      for (int s = 1; s <= lat; s++) begin
        step(1);
        if (s == len) begin pin_i = b; alt_i = b; end
      end
      chk("R1 R2 R3 R4 R5 rand flag", flag_o, expc);
      if (expc) chk("R1 R4 R5 rand cap", cap_o, c0 + 16'(lat - 1));
      pin_i = b; alt_i = b;
      step(12);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule